// File: doc/BRIEF.md
# Dual-Issue Mode Transition Sequencer

This block sits at the end of instruction fetch. Each cycle it decides whether the machine issues one 32-bit instruction or a 64-bit pair. A pair holds one floating-point instruction and one integer-core instruction. The block examines the dual-request bit carried inside floating-point instructions. Changes of issue mode are deferred: entering dual issue waits for one more single instruction, and leaving it waits for one more pair.

Upstream fetch presents an aligned 64-bit word, a valid flag and a half-select bit. The half-select bit tells which 32-bit half holds the current instruction while in single issue. The fetch logic reads the registered mode output to learn whether the next fetch is consumed as one word or as a pair. The issued instructions leave through two registered slots, each with its own valid flag.

Top module: `dual_issue_seq`

## Requirements
- R1: After reset the mode output is 0 (single issue), both slot valids are 0 and the misalignment flag is 0.
- R2: In single issue, an accepted fetch issues exactly one instruction, taken from the high half when the half-select is 1 and the low half otherwise. It goes to the FP slot when its bits [31:26] equal 6'h12 and to the core slot otherwise. Slot outputs appear in the cycle after acceptance.
- R3: In single issue, an accepted FP-class instruction with bit 9 set (the dual-request bit) leaves the mode output at 0 for one further accepted instruction, which also issues singly. The mode output then goes to 1. The dual-request bit of that further instruction does not cancel the entry.
- R4: In dual issue, an accepted fetch issues the low 32 bits on the FP slot and the high 32 bits on the core slot, both valid.
- R5: In dual issue, an accepted pair whose low half is FP-class with bit 9 clear leaves the mode at 1 for one more accepted pair. The mode then returns to 0, whatever the dual-request bit of that last pair.
- R6: If the instruction issued during the entry delay is FP-class with bit 9 clear, exactly one pair issues in dual mode before the mode returns to 0.
- R7: If the instruction issued during the entry delay comes from the low half (half-select 0), the next pair could not start on a 64-bit boundary. The misalignment flag is then 1 for that issue, and the mode stays 0.
- R8: While stall is 1 and flush is 0, mode, slot data, slot valids and the misalignment flag hold their values.
- R9: Flush, which takes priority over stall, sets the mode to 0, clears both slot valids and the misalignment flag in the next cycle, and cancels any pending entry or exit.
- R10: With fetch-valid 0, no stall and no flush, both slot valids and the misalignment flag are 0 in the next cycle, and the mode is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_word_i | input | 64 | Aligned fetch word; low half is the lower address |
| fetch_hi_i | input | 1 | Selects the high half as the single-issue instruction |
| fetch_valid_i | input | 1 | Fetch word is valid |
| stall_i | input | 1 | Hold all state and outputs |
| flush_i | input | 1 | Redirect: return to single issue, drop outputs |
| core_insn_o | output | 32 | Core-slot instruction |
| core_valid_o | output | 1 | Core slot holds an issued instruction |
| fp_insn_o | output | 32 | FP-slot instruction |
| fp_valid_o | output | 1 | FP slot holds an issued instruction |
| dual_mode_o | output | 1 | 1 when the next accepted fetch is consumed as a pair |
| misalign_o | output | 1 | Entry into dual issue would start on an odd word |

## Verification
Some properties are checked on every cycle: a single-issue acceptance fills exactly one slot, a dual acceptance fills both, a stall freezes every output, a flush or an empty fetch drops the valids, and the misalignment flag never coincides with dual mode. The bench's scenarios show the ordered behaviour no single-cycle property can capture. These are the one-instruction entry delay, the one-pair exit delay, the temporary single-pair dual window, the misaligned entry, and the rule that dual-request bits inside the delay slots are ignored. A reference model driven by fixed-seed random traffic compares slot contents and mode on every cycle.

// File: rtl/dis_pkg.sv
package dis_pkg;

  // Issue state. Bit 1 set means the next accepted fetch is a pair.
  typedef enum logic [1:0] {
    ST_SINGLE = 2'd0,
    ST_ENTER  = 2'd1,
    ST_DUAL   = 2'd2,
    ST_EXIT   = 2'd3
  } dis_state_e;

  localparam int unsigned NUM_HALVES = 2;

endpackage

// File: rtl/dis_classify.sv
module dis_classify #(
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned OPC_LSB  = 26,
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] FP_OPC = 6'h12,
  parameter int unsigned DBIT_POS = 9
) (
  input  logic [INSN_W-1:0] insn_i,
  output logic              is_fp_o,
  output logic              dbit_o
);

  localparam int unsigned OPC_MSB = OPC_LSB + OPC_W - 1;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc     = insn_i[OPC_MSB:OPC_LSB];
    is_fp_o = (opc == FP_OPC);
    dbit_o  = insn_i[DBIT_POS];
  end

endmodule

// File: rtl/dis_mode_fsm.sv
module dis_mode_fsm
  import dis_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       flush_i,
  input  logic       sel_fp_i,
  input  logic       sel_dbit_i,
  input  logic       sel_hi_i,
  input  logic       lo_fp_i,
  input  logic       lo_dbit_i,
  output dis_state_e state_o,
  output logic       misalign_d_o
);

  dis_state_e st_q, st_d;
  logic       st_en;

  // Next-state logic
  always_comb begin
    st_d         = st_q;
    misalign_d_o = 1'b0;
    if (flush_i) begin
      st_d = ST_SINGLE;
    end else if (accept_i) begin
      unique case (st_q)
        ST_SINGLE: begin
          if (sel_fp_i && sel_dbit_i) st_d = ST_ENTER;
        end
        ST_ENTER: begin
          if (!sel_hi_i) begin
            st_d         = ST_SINGLE;
            misalign_d_o = 1'b1;
          end else if (sel_fp_i && !sel_dbit_i) begin
            st_d = ST_EXIT;
          end else begin
            st_d = ST_DUAL;
          end
        end
        ST_DUAL: begin
          if (lo_fp_i && !lo_dbit_i) st_d = ST_EXIT;
        end
        ST_EXIT: begin
          st_d = ST_SINGLE;
        end
        default: st_d = ST_SINGLE;
      endcase
    end
  end

  assign st_en = accept_i | flush_i;

  // State register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_SINGLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/dis_slot_stage.sv
module dis_slot_stage #(
  parameter int unsigned INSN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              flush_i,
  input  logic              fetch_valid_i,
  input  logic              pair_i,
  input  logic [INSN_W-1:0] lo_insn_i,
  input  logic [INSN_W-1:0] hi_insn_i,
  input  logic [INSN_W-1:0] sel_insn_i,
  input  logic              sel_fp_i,
  input  logic              misalign_d_i,
  output logic [INSN_W-1:0] core_insn_o,
  output logic              core_valid_o,
  output logic [INSN_W-1:0] fp_insn_o,
  output logic              fp_valid_o,
  output logic              misalign_o
);

  logic [INSN_W-1:0] core_q, core_d, fp_q, fp_d;
  logic              core_v_q, core_v_d, fp_v_q, fp_v_d, mis_q, mis_d;
  logic              en;

  assign en = flush_i | ~stall_i;

  always_comb begin
    core_d   = '0;
    fp_d     = '0;
    core_v_d = 1'b0;
    fp_v_d   = 1'b0;
    mis_d    = 1'b0;
    if (!flush_i && fetch_valid_i) begin
      if (pair_i) begin
        fp_d     = lo_insn_i;
        core_d   = hi_insn_i;
        fp_v_d   = 1'b1;
        core_v_d = 1'b1;
      end else if (sel_fp_i) begin
        fp_d   = sel_insn_i;
        fp_v_d = 1'b1;
      end else begin
        core_d   = sel_insn_i;
        core_v_d = 1'b1;
      end
      mis_d = misalign_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q   <= '0;
      fp_q     <= '0;
      core_v_q <= 1'b0;
      fp_v_q   <= 1'b0;
      mis_q    <= 1'b0;
    end else if (en) begin
      core_q   <= core_d;
      fp_q     <= fp_d;
      core_v_q <= core_v_d;
      fp_v_q   <= fp_v_d;
      mis_q    <= mis_d;
    end
  end

  assign core_insn_o  = core_q;
  assign core_valid_o = core_v_q;
  assign fp_insn_o    = fp_q;
  assign fp_valid_o   = fp_v_q;
  assign misalign_o   = mis_q;

endmodule

// File: rtl/dual_issue_seq.sv
module dual_issue_seq
  import dis_pkg::*;
#(
  parameter int unsigned INSN_W   = 32,
  parameter int unsigned OPC_LSB  = 26,
  parameter int unsigned OPC_W    = 6,
  parameter logic [OPC_W-1:0] FP_OPC = 6'h12,
  parameter int unsigned DBIT_POS = 9,
  localparam int unsigned FETCH_W = INSN_W * NUM_HALVES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FETCH_W-1:0] fetch_word_i,
  input  logic               fetch_hi_i,
  input  logic               fetch_valid_i,
  input  logic               stall_i,
  input  logic               flush_i,
  output logic [INSN_W-1:0]  core_insn_o,
  output logic               core_valid_o,
  output logic [INSN_W-1:0]  fp_insn_o,
  output logic               fp_valid_o,
  output logic               dual_mode_o,
  output logic               misalign_o
);

  logic [INSN_W-1:0] half_insn [NUM_HALVES];
  logic              half_fp   [NUM_HALVES];
  logic              half_dbit [NUM_HALVES];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign half_insn[h] = fetch_word_i[h*INSN_W +: INSN_W];
    dis_classify #(
      .INSN_W  (INSN_W),
      .OPC_LSB (OPC_LSB),
      .OPC_W   (OPC_W),
      .FP_OPC  (FP_OPC),
      .DBIT_POS(DBIT_POS)
    ) u_cls (
      .insn_i (half_insn[h]),
      .is_fp_o(half_fp[h]),
      .dbit_o (half_dbit[h])
    );
  end

  logic [INSN_W-1:0] sel_insn;
  logic              sel_fp, sel_dbit, accept, mis_d, pair;
  dis_state_e        state;

  always_comb begin
    sel_insn = fetch_hi_i ? half_insn[1] : half_insn[0];
    sel_fp   = fetch_hi_i ? half_fp[1]   : half_fp[0];
    sel_dbit = fetch_hi_i ? half_dbit[1] : half_dbit[0];
    accept   = fetch_valid_i & ~stall_i & ~flush_i;
  end

  dis_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .flush_i     (flush_i),
    .sel_fp_i    (sel_fp),
    .sel_dbit_i  (sel_dbit),
    .sel_hi_i    (fetch_hi_i),
    .lo_fp_i     (half_fp[0]),
    .lo_dbit_i   (half_dbit[0]),
    .state_o     (state),
    .misalign_d_o(mis_d)
  );

  assign pair        = state[1];
  assign dual_mode_o = pair;

  dis_slot_stage #(.INSN_W(INSN_W)) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall_i),
    .flush_i      (flush_i),
    .fetch_valid_i(fetch_valid_i),
    .pair_i       (pair),
    .lo_insn_i    (half_insn[0]),
    .hi_insn_i    (half_insn[1]),
    .sel_insn_i   (sel_insn),
    .sel_fp_i     (sel_fp),
    .misalign_d_i (mis_d),
    .core_insn_o  (core_insn_o),
    .core_valid_o (core_valid_o),
    .fp_insn_o    (fp_insn_o),
    .fp_valid_o   (fp_valid_o),
    .misalign_o   (misalign_o)
  );

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
  parameter int unsigned INSN_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic              stall_i,
  input logic              flush_i,
  input logic [INSN_W-1:0] core_insn_o,
  input logic              core_valid_o,
  input logic [INSN_W-1:0] fp_insn_o,
  input logic              fp_valid_o,
  input logic              dual_mode_o,
  input logic              misalign_o
);

  AST_SINGLE_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_mode_o && fetch_valid_i && !stall_i && !flush_i)
      |=> ($countones({core_valid_o, fp_valid_o}) == 1)); // R2

  AST_DUAL_BOTH_SLOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_mode_o && fetch_valid_i && !stall_i && !flush_i)
      |=> (core_valid_o && fp_valid_o)); // R4

  AST_MISALIGN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !dual_mode_o); // R7

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !flush_i)
      |=> ($stable(core_insn_o) && $stable(fp_insn_o) && $stable(core_valid_o)
           && $stable(fp_valid_o) && $stable(dual_mode_o) && $stable(misalign_o))); // R8

  AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!core_valid_o && !fp_valid_o && !dual_mode_o && !misalign_o)); // R9

  AST_IDLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_valid_i && !stall_i && !flush_i)
      |=> (!core_valid_o && !fp_valid_o && $stable(dual_mode_o))); // R10

endmodule

bind dual_issue_seq dis_checker #(.INSN_W(INSN_W)) u_dis_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_valid_i(fetch_valid_i),
  .stall_i      (stall_i),
  .flush_i      (flush_i),
  .core_insn_o  (core_insn_o),
  .core_valid_o (core_valid_o),
  .fp_insn_o    (fp_insn_o),
  .fp_valid_o   (fp_valid_o),
  .dual_mode_o  (dual_mode_o),
  .misalign_o   (misalign_o)
);

// File: tb/tb_dual_issue_seq.sv
module tb_dual_issue_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] fw;
  logic        fhi, fv, st, fl;
  logic [31:0] core_insn, fp_insn;
  logic        core_v, fp_v, mode, mis;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state: 0 single, 1 entry pending, 2 dual, 3 exit pending
  int          m_st;
  logic [31:0] e_core, e_fp;
  logic        e_cv, e_fv, e_mis;

  always #5 clk = ~clk;

  dual_issue_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_word_i(fw), .fetch_hi_i(fhi),
    .fetch_valid_i(fv), .stall_i(st), .flush_i(fl),
    .core_insn_o(core_insn), .core_valid_o(core_v), .fp_insn_o(fp_insn),
    .fp_valid_o(fp_v), .dual_mode_o(mode), .misalign_o(mis)
  );

  function automatic logic [31:0] mk(bit is_fp, bit d, logic [31:0] pay);
    logic [31:0] r;
    r     = {(is_fp ? 6'h12 : 6'h05), pay[25:0]};
    r[9]  = d;
    return r;
  endfunction

  function automatic bit cls_fp(logic [31:0] i);
    return i[31:26] == 6'h12;
  endfunction

  task automatic model_edge();
    logic [31:0] s;
    if (fl) begin
      m_st = 0; e_cv = 0; e_fv = 0; e_mis = 0;
    end else if (st) begin
      // hold
    end else if (!fv) begin
      e_cv = 0; e_fv = 0; e_mis = 0;
    end else begin
      e_mis = 0;
      if (m_st >= 2) begin
        e_fp = fw[31:0]; e_core = fw[63:32]; e_fv = 1; e_cv = 1;
        if (m_st == 3) m_st = 0;
        else if (cls_fp(fw[31:0]) && !fw[9]) m_st = 3;
      end else begin
        s = fhi ? fw[63:32] : fw[31:0];
        if (cls_fp(s)) begin e_fp = s; e_fv = 1; e_cv = 0; end
        else begin e_core = s; e_cv = 1; e_fv = 0; end
        if (m_st == 0) begin
          if (cls_fp(s) && s[9]) m_st = 1;
        end else begin
          if (!fhi) begin m_st = 0; e_mis = 1; end
          else if (cls_fp(s) && !s[9]) m_st = 3;
          else m_st = 2;
        end
      end
    end
  endtask

  task automatic chk1(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk1(tag, "mode", {31'd0, mode}, {31'd0, (m_st >= 2)});
    chk1(tag, "core_valid", {31'd0, core_v}, {31'd0, e_cv});
    chk1(tag, "fp_valid", {31'd0, fp_v}, {31'd0, e_fv});
    chk1(tag, "misalign", {31'd0, mis}, {31'd0, e_mis});
    if (e_cv) chk1(tag, "core_insn", core_insn, e_core);
    if (e_fv) chk1(tag, "fp_insn", fp_insn, e_fp);
  endtask

  task automatic step(logic [63:0] w, bit hi, bit v, bit s, bit f, string tag);
    @(negedge clk);
    fw = w; fhi = hi; fv = v; st = s; fl = f;
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed  = 32'd1234;
    void'($urandom(seed));
    rst_n = 0; fw = '0; fhi = 0; fv = 0; st = 0; fl = 0;
    m_st = 0; e_core = '0; e_fp = '0; e_cv = 0; e_fv = 0; e_mis = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 compare("R1");

    // R2: single issue routing by class and half
    step({mk(0,0,32'h111), mk(1,0,32'h222)}, 0, 1, 0, 0, "R2");
    step({mk(0,0,32'h333), mk(1,0,32'h444)}, 1, 1, 0, 0, "R2");
    // R3: entry with one-instruction delay; D bit in delay slot ignored
    step({mk(0,0,32'h1), mk(1,1,32'h2)}, 0, 1, 0, 0, "R3");
    step({mk(1,1,32'h3), mk(0,0,32'h4)}, 1, 1, 0, 0, "R3");
    // R4: dual pairs, low FP / high core
    step({mk(0,0,32'h55), mk(1,1,32'h66)}, 0, 1, 0, 0, "R4");
    step({mk(0,1,32'h77), mk(0,0,32'h88)}, 0, 1, 0, 0, "R4");
    // R5: exit with one-pair delay
    step({mk(0,0,32'h99), mk(1,0,32'haa)}, 0, 1, 0, 0, "R5");
    step({mk(0,0,32'hbb), mk(1,1,32'hcc)}, 0, 1, 0, 0, "R5");
    step({mk(0,0,32'hdd), mk(1,0,32'hee)}, 0, 1, 0, 0, "R5");
    // R6: temporary dual window of one pair
    step({mk(0,0,32'h5), mk(1,1,32'h6)}, 0, 1, 0, 0, "R6");
    step({mk(1,0,32'h7), mk(0,0,32'h8)}, 1, 1, 0, 0, "R6");
    step({mk(0,0,32'h9), mk(1,1,32'ha)}, 0, 1, 0, 0, "R6");
    step({mk(0,0,32'hb), mk(0,0,32'hc)}, 0, 1, 0, 0, "R6");
    // R7: entry delay instruction in low half
    step({mk(1,1,32'hd), mk(0,0,32'he)}, 1, 1, 0, 0, "R7");
    step({mk(0,0,32'hf), mk(0,0,32'h10)}, 0, 1, 0, 0, "R7");
    step({mk(0,0,32'h11), mk(0,0,32'h12)}, 0, 1, 0, 0, "R7");
    // R8: stall holds during pending entry
    step({mk(0,0,32'h13), mk(1,1,32'h14)}, 0, 1, 0, 0, "R8");
    step({mk(1,0,32'h15), mk(1,0,32'h16)}, 1, 1, 1, 0, "R8");
    step({mk(1,0,32'h17), mk(1,0,32'h18)}, 0, 0, 1, 0, "R8");
    step({mk(0,0,32'h19), mk(0,0,32'h1a)}, 1, 1, 0, 0, "R8");
    // R9: flush in dual, with stall
    step({mk(0,0,32'h1b), mk(1,1,32'h1c)}, 0, 1, 0, 0, "R9");
    step({mk(0,0,32'h1d), mk(1,1,32'h1e)}, 0, 1, 1, 1, "R9");
    step({mk(0,0,32'h1f), mk(1,1,32'h20)}, 1, 1, 0, 1, "R9");
    // R10: no fetch
    step({mk(0,0,32'h21), mk(1,1,32'h22)}, 0, 0, 0, 0, "R10");
    step({mk(0,0,32'h23), mk(1,1,32'h24)}, 0, 1, 0, 0, "R10");
    step({mk(0,0,32'h25), mk(1,1,32'h26)}, 0, 0, 0, 0, "R10");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] w;
      bit hi, v, s, f;
      w  = {mk(($urandom % 3) == 0, $urandom % 2, $urandom),
            mk(($urandom % 2) == 0, ($urandom % 3) != 0, $urandom)};
      v  = ($urandom % 8) != 0;
      s  = ($urandom % 8) == 0;
      f  = ($urandom % 40) == 0;
      hi = (m_st >= 2) ? 1'b0 : (($urandom % 5) != 0);
      step(w, hi, v, s, f, "RND R2 R3 R4 R5 R6 R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule